// File: doc/BRIEF.md
# Double-Handshake Bus Slave Receiver

This block receives a message from a master over a double-handshake bus. The bus has a ready line and a 16-bit address driven by the master, a 32-bit data word, and an ack line driven by this slave. Before a message, the block is armed with a `start` pulse. That pulse loads the channel address the block answers to and the number of words it expects.

For each word, the block waits until the master raises ready with the matching address. It stores the data word through a one-cycle write port, tagged with the word's position in the message. After a set number of cycles it raises ack. It then holds ack until the master drops ready, and lowers ack a set number of cycles after that. Once the expected count is used up, the block pulses `done` and goes idle until the next `start`.

Ready and the address reach the control logic only after a chain of synchronizer flops, because the master may run on a different clock. The master keeps the data word stable while ready is high, so the data is captured without synchronization.

Top module: `hs_slave_rx`

## Requirements
- R1: After reset, `bus_ack`, `wr_en` and `done` are low and the block is disarmed: a handshake is ignored (no ack, no write) until `start` arms it, even one whose address matches the reset value 0x0000.
- R2: A `start` pulse accepted while the block waits for a handshake loads `cfg_addr` as the channel address and `cfg_words` as the word count, and resets the word position to 0. A `start` pulse given while a word handshake is in progress is ignored: the message in flight keeps its address and count.
- R3: While the synchronized ready is low, or while the synchronized address differs from the channel address, the block raises no ack and issues no write.
- R4: Each accepted word produces exactly one single-cycle `wr_en` pulse. On that pulse, `wr_data` is the bus word and `wr_idx` is its position in the message, counting 0, 1, 2 and so on. `wr_en` is never high while `bus_ack` is high.
- R5: `bus_ack` rises exactly SYNC_STAGES+1+ACK_DLY clock edges after the edge that follows the master raising ready with a matching address. Of these, SYNC_STAGES edges are synchronizer stages, one edge is the match, and ACK_DLY is the programmed assert delay.
- R6: `bus_ack` stays high until ready falls. It then drops exactly SYNC_STAGES+1+REL_DLY edges after ready goes low.
- R7: `done` is a one-cycle pulse. It is registered on the same edge at which `bus_ack` falls for the last word of the message. After it, the block is disarmed, and further handshakes to the old address are ignored.
- R8: A `start` with `cfg_words` = 0 pulses `done` on the next edge and leaves the block disarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arms the block: loads channel address and word count |
| cfg_addr | input | 16 | Channel address to answer |
| cfg_words | input | CNT_W | Number of words in the message |
| bus_ready | input | 1 | Master ready line (asynchronous) |
| bus_addr | input | 16 | Master address lines (asynchronous) |
| bus_data | input | 32 | Data word, stable while ready is high |
| bus_ack | output | 1 | Slave acknowledge |
| wr_en | output | 1 | One-cycle local word write strobe |
| wr_idx | output | CNT_W | Position of the written word within the message |
| wr_data | output | 32 | Word to write |
| done | output | 1 | One-cycle pulse when the message is complete |

## Verification
A wrong control state shows up at the ports within one handshake:
- An ack edge arrives a cycle early or late against the fixed latencies.
- A write strobe appears for a foreign address.
- A word is written with the wrong position or data.
- `done` fires too early, too late or not at all.

A broken count or a broken arming flag shows up at the end of a message. Either `done` is missing, or a handshake that should be ignored gets acknowledged. The scoreboard flags any write that is unexpected, missing or carries the wrong data at the cycle it happens.

// File: rtl/hs_rx_pkg.sv
package hs_rx_pkg;
    localparam int HS_ADDR_W = 16;
    localparam int HS_DATA_W = 32;

    typedef enum logic [2:0] {
        ST_SAMPLE  = 3'd0,  // wait for ready with matching address
        ST_XFER    = 3'd1,  // word captured, count assert delay
        ST_RAISE   = 3'd2,  // raise ack, consume one word
        ST_HOLD    = 3'd3,  // wait for ready to fall
        ST_DROP    = 3'd4   // count release delay, then lower ack
    } hs_state_e;
endpackage

// File: rtl/hs_rx_sync.sv
module hs_rx_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hs_rx_ctrl.sv
module hs_rx_ctrl
    import hs_rx_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int ACK_DLY = 3,
    parameter int REL_DLY = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [HS_ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]     cfg_words,
    input  logic                 rdy_s,
    input  logic [HS_ADDR_W-1:0] addr_s,
    input  logic [HS_DATA_W-1:0] bus_data,
    output logic                 bus_ack,
    output logic                 wr_en,
    output logic [CNT_W-1:0]     wr_idx,
    output logic [HS_DATA_W-1:0] wr_data,
    output logic                 done,
    output logic [HS_ADDR_W-1:0] tgt_addr
);
    localparam int MAX_DLY = (ACK_DLY > REL_DLY) ? ACK_DLY : REL_DLY;
    localparam int WAIT_W  = $clog2(MAX_DLY + 1);
    // ACK_DLY counts edges from the match to ack; XFER and RAISE take
    // at least one edge each, so the wait counter starts at ACK_DLY-2.
    localparam logic [WAIT_W-1:0] ACK_WAIT = WAIT_W'(ACK_DLY - 2);
    localparam logic [WAIT_W-1:0] REL_WAIT = WAIT_W'(REL_DLY - 1);

    typedef struct packed {
        hs_state_e              state;
        logic [WAIT_W-1:0]      wait_cnt;
        logic [CNT_W-1:0]       remain;
        logic [CNT_W-1:0]       idx;
        logic [HS_ADDR_W-1:0]   tgt;
        logic                   armed;
        logic                   ack;
        logic                   wr_en;
        logic [HS_DATA_W-1:0]   wr_data;
        logic                   done;
    } ctrl_t;

    ctrl_t r_q, r_d;

    always_comb begin
        r_d         = r_q;
        r_d.wr_en   = 1'b0;
        r_d.done    = 1'b0;
        unique case (r_q.state)
            ST_SAMPLE: begin
                if (start) begin
                    r_d.tgt    = cfg_addr;
                    r_d.remain = cfg_words;
                    r_d.idx    = '0;
                    if (cfg_words == '0) begin
                        r_d.done  = 1'b1;
                        r_d.armed = 1'b0;
                    end else begin
                        r_d.armed = 1'b1;
                    end
                end else if (r_q.armed && rdy_s && (addr_s == r_q.tgt)) begin
                    r_d.state    = ST_XFER;
                    r_d.wr_en    = 1'b1;
                    r_d.wr_data  = bus_data;
                    r_d.wait_cnt = ACK_WAIT;
                end
            end
            ST_XFER: begin
                if (r_q.wait_cnt == '0) r_d.state    = ST_RAISE;
                else                    r_d.wait_cnt = r_q.wait_cnt - 1'b1;
            end
            ST_RAISE: begin
                r_d.ack    = 1'b1;
                r_d.remain = r_q.remain - 1'b1;
                r_d.idx    = r_q.idx + 1'b1;
                r_d.state  = ST_HOLD;
            end
            ST_HOLD: begin
                if (!rdy_s) begin
                    r_d.state    = ST_DROP;
                    r_d.wait_cnt = REL_WAIT;
                end
            end
            ST_DROP: begin
                if (r_q.wait_cnt == '0) begin
                    r_d.ack   = 1'b0;
                    r_d.state = ST_SAMPLE;
                    if (r_q.remain == '0) begin
                        r_d.done  = 1'b1;
                        r_d.armed = 1'b0;
                    end
                end else begin
                    r_d.wait_cnt = r_q.wait_cnt - 1'b1;
                end
            end
            default: r_d.state = ST_SAMPLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_SAMPLE;
            r_q.wait_cnt <= '0;
            r_q.remain   <= '0;
            r_q.idx      <= '0;
            r_q.tgt      <= '0;
            r_q.armed    <= 1'b0;
            r_q.ack      <= 1'b0;
            r_q.wr_en    <= 1'b0;
            r_q.wr_data  <= '0;
            r_q.done     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_ack  = r_q.ack;
    assign wr_en    = r_q.wr_en;
    assign wr_idx   = r_q.idx;
    assign wr_data  = r_q.wr_data;
    assign done     = r_q.done;
    assign tgt_addr = r_q.tgt;
endmodule

// File: rtl/hs_slave_rx.sv
module hs_slave_rx
    import hs_rx_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int ACK_DLY     = 3,   // >= 2
    parameter int REL_DLY     = 2,   // >= 1
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [HS_ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]     cfg_words,
    input  logic                 bus_ready,
    input  logic [HS_ADDR_W-1:0] bus_addr,
    input  logic [HS_DATA_W-1:0] bus_data,
    output logic                 bus_ack,
    output logic                 wr_en,
    output logic [CNT_W-1:0]     wr_idx,
    output logic [HS_DATA_W-1:0] wr_data,
    output logic                 done
);
    localparam int SYNC_W = HS_ADDR_W + 1;

    logic [SYNC_W-1:0]    sync_q;
    logic                 ready_sync;
    logic [HS_ADDR_W-1:0] addr_sync;
    logic [HS_ADDR_W-1:0] tgt_addr;

    hs_rx_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_ready, bus_addr}),
        .q     (sync_q)
    );

    assign ready_sync = sync_q[SYNC_W-1];
    assign addr_sync  = sync_q[HS_ADDR_W-1:0];

    hs_rx_ctrl #(.CNT_W(CNT_W), .ACK_DLY(ACK_DLY), .REL_DLY(REL_DLY)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_addr  (cfg_addr),
        .cfg_words (cfg_words),
        .rdy_s     (ready_sync),
        .addr_s    (addr_sync),
        .bus_data  (bus_data),
        .bus_ack   (bus_ack),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .done      (done),
        .tgt_addr  (tgt_addr)
    );
endmodule

// File: rtl/hs_slave_rx_chk.sv
module hs_slave_rx_chk #(
    parameter int ACK_DLY = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_ack,
    input logic        wr_en,
    input logic        done,
    input logic        ready_sync,
    input logic [15:0] addr_sync,
    input logic [15:0] tgt_addr
);
    logic [7:0] since_wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_wr_q <= 8'hFF;
        else if (wr_en)           since_wr_q <= 8'd0;
        else if (since_wr_q != 8'hFF) since_wr_q <= since_wr_q + 8'd1;
    end

    // R3
    write_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(ready_sync && (addr_sync == tgt_addr)));

    // R4
    write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R4
    write_ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !bus_ack);

    // R5
    ack_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> (since_wr_q == 8'(ACK_DLY - 1)));

    // R6
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ack) |-> $past(!ready_sync));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_ack);
endmodule

bind hs_slave_rx hs_slave_rx_chk #(.ACK_DLY(ACK_DLY)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ack    (bus_ack),
    .wr_en      (wr_en),
    .done       (done),
    .ready_sync (ready_sync),
    .addr_sync  (addr_sync),
    .tgt_addr   (tgt_addr)
);

// File: tb/hs_slave_rx_bench.sv
module hs_slave_rx_bench;
    localparam int CNT_W = 8;
    localparam int ACK_DLY = 3;
    localparam int REL_DLY = 2;
    localparam int SYNC = 2;
    localparam int RISE_LAT = SYNC + 1 + ACK_DLY;
    localparam int FALL_LAT = SYNC + 1 + REL_DLY;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [CNT_W-1:0] cfg_words = '0;
    logic bus_ready = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic bus_ack, wr_en, done;
    logic [CNT_W-1:0] wr_idx;
    logic [31:0] wr_data;

    int checks = 0;
    int errors = 0;
    int next_idx = 0;
    bit finished = 1'b0;
    int exp_idx[$];
    logic [31:0] exp_data[$];

    always #10 clk = ~clk;

    hs_slave_rx #(.CNT_W(CNT_W), .ACK_DLY(ACK_DLY), .REL_DLY(REL_DLY),
                  .SYNC_STAGES(SYNC)) u_hs_slave_rx (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_addr(cfg_addr),
        .cfg_words(cfg_words), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_ack(bus_ack), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares every write against the scoreboard queue (R4)
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (exp_idx.size() == 0) begin
                check(1'b0, "R3 unexpected write", longint'(wr_data), 0);
            end else begin
                int ei;
                logic [31:0] ed;
                ei = exp_idx.pop_front();
                ed = exp_data.pop_front();
                check(wr_idx == CNT_W'(ei), "R4 word index", longint'(wr_idx), longint'(ei));
                check(wr_data == ed, "R4 word data", longint'(wr_data), longint'(ed));
            end
        end
    end

    task automatic arm(input logic [15:0] a, input int n);
        @(negedge clk);
        start = 1'b1; cfg_addr = a; cfg_words = CNT_W'(n);
        @(negedge clk);
        start = 1'b0;
        next_idx = 0;
    endtask

    task automatic word(input logic [15:0] a, input logic [31:0] d,
                        input bit accept, input bit last, input bit poke);
        int n;
        bit seen;
        if (accept) begin
            exp_idx.push_back(next_idx);
            exp_data.push_back(d);
            next_idx++;
        end
        @(negedge clk);
        bus_addr = a; bus_data = d; bus_ready = 1'b1;
        if (accept) begin
            n = 0;
            do begin @(negedge clk); n++; end while (!bus_ack && n < 50);
            check(n == RISE_LAT, "R5 ack rise latency", n, RISE_LAT);
            if (poke) begin
                start = 1'b1; cfg_addr = 16'hBEEF; cfg_words = CNT_W'(5);
                @(negedge clk);
                start = 1'b0;
                check(bus_ack == 1'b1, "R6 ack held while ready high", bus_ack, 1);
            end
            bus_ready = 1'b0;
            n = 0;
            do begin @(negedge clk); n++; end while (bus_ack && n < 50);
            check(n == FALL_LAT, "R6 ack fall latency", n, FALL_LAT);
            check(done == last, "R7 done with last ack fall", done, last);
            @(negedge clk);
            check(done == 1'b0, "R7 done is one cycle", done, 0);
        end else begin
            seen = 1'b0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (bus_ack) seen = 1'b1;
            end
            check(!seen, "R3 ignored handshake gives no ack", seen, 0);
            bus_ready = 1'b0;
            for (int i = 0; i < 6; i++) @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(bus_ack == 1'b0 && wr_en == 1'b0 && done == 1'b0, "R1 reset outputs",
              {bus_ack, wr_en, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: disarmed after reset, even address 0000 is ignored
        word(16'h0000, 32'h1111_2222, 1'b0, 1'b0, 1'b0);

        // R2: arm for three words at 0x1234
        arm(16'h1234, 3);
        word(16'h1235, 32'hAAAA_5555, 1'b0, 1'b0, 1'b0);   // R3 foreign address
        word(16'h1234, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0);
        word(16'h1234, 32'h0000_0000, 1'b1, 1'b0, 1'b0);
        word(16'h1234, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0);
        // R7: disarmed after completion
        word(16'h1234, 32'h0BAD_0BAD, 1'b0, 1'b0, 1'b0);

        // R8: zero-word start
        @(negedge clk);
        start = 1'b1; cfg_addr = 16'h4321; cfg_words = '0;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R8 done after zero-count start", done, 1);
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", done, 0);
        word(16'h4321, 32'h1357_9BDF, 1'b0, 1'b0, 1'b0);

        // R2: start during a handshake is ignored
        arm(16'hFFFF, 2);
        word(16'hFFFF, 32'h8000_0001, 1'b1, 1'b0, 1'b1);
        word(16'hFFFF, 32'h7FFF_FFFE, 1'b1, 1'b1, 1'b0);
        word(16'hBEEF, 32'h2468_ACE0, 1'b0, 1'b0, 1'b0);

        repeat (3) @(negedge clk);
        check(exp_idx.size() == 0, "R4 all expected writes seen", exp_idx.size(), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule